// File: doc/BRIEF.md
# Strided Access Bank Conflict Checker

This block sits in front of a memory split into independently addressed banks and plays out one strided vector access. After a start pulse it takes a base address, a stride and an element count. It then offers one element address per cycle and maps each address to a bank by low-order interleaving. Each bank has a busy timer. The timer models a bank cycle that is several processor cycles long.

When the next element's bank is still busy, the block holds that address and counts a stall cycle. At the end of the access it reports the total number of stalls and a sticky conflict flag. A stride that shares a large common factor with the bank count sends accesses back to a few banks, and the stall total shows how much that costs. Data storage is not part of this block. It serves a single requester.

Top module: `bank_conflict_checker`

## Requirements
- R1: After reset the block is idle: busy, issue_valid and done are 0, stall_count is 0 and conflict is 0.
- R2: The first element address equals base_addr and appears one cycle after start is accepted. The i-th issued address is base_addr + i*stride modulo 2^ADDR_W, so addresses wrap past the top of the address space.
- R3: issue_bank equals the low log2(NUM_BANKS) bits of issue_addr (address modulo NUM_BANKS; the default is 8 banks, so bits [2:0]).
- R4: Two accesses to the same bank issue at least BUSY_CYC cycles apart (default 7). An element issues in the first cycle its bank is no longer busy. Bank timers keep running across accesses.
- R5: While the target bank is busy, issue_valid is 0, issue_addr holds its value, and stall_count grows by one each held cycle.
- R6: With unit stride and NUM_BANKS >= BUSY_CYC, an access of N elements issues in N consecutive cycles with zero stalls and conflict 0.
- R7: A stride of zero is legal. Each element waits for the previous one's bank, so N elements take (N-1)*BUSY_CYC+1 cycles and (N-1)*(BUSY_CYC-1) stalls.
- R8: done pulses for one cycle in the cycle after the last element issues. busy falls in that same cycle.
- R9: conflict goes to 1 on the first stall and stays set until the next accepted start. An accepted start clears both conflict and stall_count.
- R10: start is ignored while busy is 1. The ongoing address sequence is unchanged.
- R11: A start with elem_count of zero issues nothing and pulses done in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an access (accepted only while idle) |
| base_addr | input | ADDR_W | Address of element 0 |
| stride | input | ADDR_W | Address step between elements |
| elem_count | input | CNT_W | Number of elements |
| busy | output | 1 | Access in progress |
| issue_valid | output | 1 | issue_addr is sent to its bank this cycle |
| issue_addr | output | ADDR_W | Current element address |
| issue_bank | output | BANK_W | Bank index of issue_addr |
| done | output | 1 | One-cycle pulse at the end of an access |
| stall_count | output | STALL_W | Stall cycles of the latest access |
| conflict | output | 1 | At least one stall in the latest access |

## Verification
Start is accepted on a clock edge. The first address, or the done pulse for a zero-length access, is visible in the very next cycle. After that, every issue slot falls at a cycle offset that a per-bank reference schedule predicts. done and the final stall total appear one cycle after the last predicted issue. The bench drives start at a falling edge and samples at every falling edge after it. It compares each cycle's issue_valid, address, bank, busy and done against the predicted schedule, so a result that comes one cycle early or late is caught where it happens.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } run_state_e;
endpackage

// File: rtl/bcc_addr_gen.sv
module bcc_addr_gen #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 8,
   parameter int BANK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              advance_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] stride_i,
   input  logic [CNT_W-1:0]  count_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BANK_W-1:0] bank_o,
   output logic              last_o
);
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] step_q;
   logic [CNT_W-1:0]  left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         step_q <= '0;
         left_q <= '0;
      end else if (load_i) begin
         addr_q <= base_i;
         step_q <= stride_i;
         left_q <= count_i;
      end else if (advance_i) begin
         addr_q <= addr_q + step_q;
         left_q <= left_q - 1'b1;
      end
   end

   assign addr_o = addr_q;
   assign bank_o = addr_q[BANK_W-1:0];
   assign last_o = (left_q == CNT_W'(1));

   // R5: a held element keeps its address
   assert_hold_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !advance_i) |=> (addr_o == $past(addr_o)));
endmodule

// File: rtl/bcc_bank_timers.sv
module bcc_bank_timers #(
   parameter int NUM_BANKS = 8,
   parameter int BUSY_CYC  = 7,
   parameter int BANK_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  logic [BANK_W-1:0] bank_i,
   output logic              free_o
);
   localparam int TMR_W = $clog2(BUSY_CYC + 1);
   localparam logic [TMR_W-1:0] RELOAD = TMR_W'(BUSY_CYC - 1);

   logic [TMR_W-1:0] tmr_q [NUM_BANKS];

   generate
      if (BUSY_CYC > 1) begin : g_timed
         for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            always_ff @(posedge clk) begin
               if (!rst_n)
                  tmr_q[b] <= '0;
               else if (issue_i && (bank_i == BANK_W'(b)))
                  tmr_q[b] <= RELOAD;
               else if (tmr_q[b] != '0)
                  tmr_q[b] <= tmr_q[b] - 1'b1;
            end
         end
      end else begin : g_single_cycle
         for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign tmr_q[b] = '0;
         end
      end
   endgenerate

   assign free_o = (tmr_q[bank_i] == '0);

   // R4: an access may only reach a bank whose timer has run out
   assert_bank_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i |-> (tmr_q[bank_i] == '0));
endmodule

// File: rtl/bank_conflict_checker.sv
module bank_conflict_checker #(
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 8,
   parameter int NUM_BANKS = 8,
   parameter int BUSY_CYC  = 7,
   parameter int STALL_W   = 16,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ADDR_W-1:0]  base_addr,
   input  logic [ADDR_W-1:0]  stride,
   input  logic [CNT_W-1:0]   elem_count,
   output logic               busy,
   output logic               issue_valid,
   output logic [ADDR_W-1:0]  issue_addr,
   output logic [BANK_W-1:0]  issue_bank,
   output logic               done,
   output logic [STALL_W-1:0] stall_count,
   output logic               conflict
);
   import bcc_pkg::*;

   generate
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two and at least 2");
      end
      if (BUSY_CYC < 1) begin : g_bad_busy
         $error("BUSY_CYC must be at least 1");
      end
      if (ADDR_W < BANK_W) begin : g_bad_addr
         $error("ADDR_W must cover the bank index");
      end
   endgenerate

   run_state_e state_q;
   logic       accept;
   logic       bank_free;
   logic       last_elem;
   logic       grant;
   logic       done_q;
   logic       conflict_q;
   logic [STALL_W-1:0] stall_q;

   assign accept = (state_q == ST_IDLE) && start;
   assign grant  = (state_q == ST_RUN) && bank_free;

   bcc_addr_gen #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .BANK_W (BANK_W)
   ) u_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (accept),
      .advance_i (grant),
      .base_i    (base_addr),
      .stride_i  (stride),
      .count_i   (elem_count),
      .addr_o    (issue_addr),
      .bank_o    (issue_bank),
      .last_o    (last_elem)
   );

   bcc_bank_timers #(
      .NUM_BANKS (NUM_BANKS),
      .BUSY_CYC  (BUSY_CYC),
      .BANK_W    (BANK_W)
   ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .issue_i (grant),
      .bank_i  (issue_bank),
      .free_o  (bank_free)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         done_q     <= 1'b0;
         conflict_q <= 1'b0;
         stall_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            stall_q    <= '0;
            conflict_q <= 1'b0;
            if (elem_count == '0)
               done_q <= 1'b1;
            else
               state_q <= ST_RUN;
         end else if (state_q == ST_RUN) begin
            if (grant) begin
               if (last_elem) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
            end else begin
               stall_q    <= stall_q + 1'b1;
               conflict_q <= 1'b1;
            end
         end
      end
   end

   assign busy        = (state_q == ST_RUN);
   assign issue_valid = grant;
   assign done        = done_q;
   assign stall_count = stall_q;
   assign conflict    = conflict_q;

   // R5: each held cycle adds one stall
   assert_stall_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !issue_valid) |=> (stall_count == $past(stall_count) + 1'b1));

   // R8: the end of an access is marked by done
   assert_done_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R9: conflict stays set until a new access is accepted
   assert_conflict_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (conflict && !(start && !busy)) |=> conflict);

   // R10: start during an access leaves the address untouched
   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !issue_valid) |=> (issue_addr == $past(issue_addr)));
endmodule

// File: tb/sim_bank_conflict_checker.sv
module sim_bank_conflict_checker;
   localparam int NB   = 8;
   localparam int BUSY = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] base_addr = '0;
   logic [15:0] stride = '0;
   logic [7:0]  elem_count = '0;
   logic        busy, issue_valid, done, conflict;
   logic [15:0] issue_addr;
   logic [2:0]  issue_bank;
   logic [15:0] stall_count;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   bank_conflict_checker u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .stride(stride), .elem_count(elem_count), .busy(busy),
      .issue_valid(issue_valid), .issue_addr(issue_addr),
      .issue_bank(issue_bank), .done(done), .stall_count(stall_count),
      .conflict(conflict)
   );

   task automatic check(string req, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Runs one access and compares every cycle against a per-bank schedule.
   task automatic run_case(logic [15:0] base, logic [15:0] stp, int n,
                           bit poke, output int stalls);
      int          t_exp [64];
      logic [15:0] a_exp [64];
      int          free_at [NB];
      int          t;
      int          k;
      int          last;
      for (int b = 0; b < NB; b++) free_at[b] = 0;
      t = 0;
      for (int i = 0; i < n; i++) begin
         a_exp[i] = base + 16'(i) * stp;
         if (t < free_at[a_exp[i] % NB]) t = free_at[a_exp[i] % NB];
         t_exp[i] = t;
         free_at[a_exp[i] % NB] = t + BUSY;
         t++;
      end
      last = (n == 0) ? -1 : t_exp[n-1];
      stalls = (n == 0) ? 0 : last + 1 - n;
      @(negedge clk);
      base_addr = base; stride = stp; elem_count = 8'(n); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k = 0;
      for (int j = 0; j <= last + 1; j++) begin
         if (j > 0) @(negedge clk);
         if (poke && j == 1) begin
            base_addr = 16'h5555; stride = 16'd1; elem_count = 8'd3; start = 1'b1;
         end else start = 1'b0;
         if (k < n && t_exp[k] == j) begin
            check("R4", "issue_valid", issue_valid, 1);
            check("R2", "issue_addr", issue_addr, a_exp[k]);
            check("R3", "issue_bank", issue_bank, a_exp[k] % NB);
            k++;
         end else if (j <= last) begin
            check("R5", "held issue_valid", issue_valid, 0);
            check("R5", "held addr", issue_addr, a_exp[k]);
         end
         check("R8", "busy", busy, (j <= last) ? 1 : 0);
         check("R8", "done", done, (j == last + 1) ? 1 : 0);
      end
      start = 1'b0;
      check("R5", "stall_count", stall_count, stalls);
      check("R9", "conflict", conflict, (stalls > 0) ? 1 : 0);
      @(negedge clk);
      check("R8", "done one cycle", done, 0);
      repeat (BUSY + 2) @(negedge clk);
   endtask

   task automatic test_reset();
      check("R1", "busy", busy, 0);
      check("R1", "issue_valid", issue_valid, 0);
      check("R1", "done", done, 0);
      check("R1", "stall_count", stall_count, 0);
      check("R1", "conflict", conflict, 0);
   endtask

   task automatic test_unit_stride();
      int s;
      run_case(16'h0010, 16'd1, 16, 1'b0, s);
      check("R6", "unit stride stalls", s, 0);
      check("R6", "unit stride conflict", conflict, 0);
   endtask

   task automatic test_zero_stride();
      int s;
      run_case(16'h0023, 16'd0, 5, 1'b0, s);
      check("R7", "zero stride stalls", stall_count, 4 * (BUSY - 1));
   endtask

   task automatic test_even_strides();
      int s;
      run_case(16'h0000, 16'd2, 12, 1'b0, s);
      check("R4", "stride 2 stalls", stall_count, s);
      run_case(16'h0101, 16'd8, 4, 1'b0, s);
      check("R4", "stride 8 stalls", stall_count, 3 * (BUSY - 1));
   endtask

   task automatic test_odd_stride();
      int s;
      run_case(16'h0007, 16'd3, 10, 1'b0, s);
      check("R3", "stride 3 stalls", stall_count, 0);
   endtask

   task automatic test_wrap();
      int s;
      run_case(16'hFFFE, 16'd1, 4, 1'b0, s);
      check("R2", "wrap stalls", stall_count, 0);
   endtask

   task automatic test_start_ignored();
      int s;
      run_case(16'h0040, 16'd4, 6, 1'b1, s);
      check("R10", "poked run stalls", stall_count, s);
      check("R10", "idle after poked run", busy, 0);
   endtask

   task automatic test_clear_on_start();
      int s;
      run_case(16'h0000, 16'd0, 3, 1'b0, s);
      check("R9", "conflict after zero stride", conflict, 1);
      run_case(16'h0000, 16'd1, 8, 1'b0, s);
      check("R9", "conflict cleared", conflict, 0);
      check("R9", "stalls cleared", stall_count, 0);
   endtask

   task automatic test_zero_count();
      int s;
      run_case(16'h0000, 16'd0, 3, 1'b0, s);
      run_case(16'h1234, 16'd1, 0, 1'b0, s);
      check("R11", "no issue for zero count", issue_valid, 0);
      check("R11", "zero count clears stalls", stall_count, 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_unit_stride();
      test_zero_stride();
      test_even_strides();
      test_odd_stride();
      test_wrap();
      test_start_ignored();
      test_clear_on_start();
      test_zero_count();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule